// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the write-cycle latch of a parallel NOR-flash interface. It sees one write per `wr_en` pulse, with the latched address and data, and it recognises the multi-cycle unlock command sequences. When a sequence completes, it fires a one-cycle strobe for the requested operation to the embedded algorithm engine. With the strobe it presents the address and data of the write that completed the sequence.

A shared two-write unlock prefix leads into one of several branches:
- program;
- identification-mode entry or exit;
- protection-register program or lock;
- a second unlock pair that ends in chip erase, sector erase, sector lock or entry into the single-pulse program mode.

Erase suspend, erase resume and identification exit are also accepted as lone writes. The block keeps two mode flags:
- the identification mode;
- the sticky single-pulse mode, in which every write is a program.

While the engine reports busy, writes are not decoded at all.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_n` is low and after it rises, no strobe is active, and both `id_mode` and `sp_mode` read 0. Reset also returns the sequence to idle and clears both modes.
- R2: A sequence starts with a write of byte AA at address 555. The next write must be byte 55 at an address whose bits 10:0 equal 2AA, so AAA and 2AA both match. Only address bits 10:0 and data bits 7:0 are compared for command cycles.
- R3: A third write of A0 at 555 makes the fourth write a program. `pgm_stb` is high for one cycle, one clock after that write, with `op_addr`/`op_data` equal to its address and data.
- R4: A third write of 90 at 555 pulses `id_enter_stb` and sets `id_mode`. A third write of F0 at 555, or a lone write of F0 at any address, pulses `id_exit_stb` and clears `id_mode`.
- R5: After the prefix, 80 at 555, AA at 555 and 55 at 2AA, the sixth write selects the erase. Byte 10 at 555 pulses `chip_erase_stb`. Byte 30 at any address pulses `sec_erase_stb` with that address on `op_addr`.
- R6: The same prefix with a sixth write of 60 pulses `sec_lock_stb` with the sector address on `op_addr`.
- R7: From idle, a lone write of B0 at any address pulses `susp_stb`. A lone write of 30 pulses `resume_stb`, and `op_addr[20:19]` carries the plane that the write selected.
- R8: A third write of C0 at 555 makes the fourth write a protection-register access. At address 080 with data bit 1 equal to 0, it pulses `prot_lock_stb`. At address 080 with bit 1 equal to 1, no strobe fires. At any other address, it pulses `prot_pgm_stb`.
- R9: A write that does not match the expected step returns the decoder to idle with no strobe. The writes that follow are then decoded from idle.
- R10: A write made while `busy` is high produces no strobe and leaves the sequence state and the modes unchanged.
- R11: The prefix with a sixth write of A0 at 555 sets `sp_mode` with no strobe. In that mode every write pulses `pgm_stb`, even bytes B0, 30 and 80, and only reset clears the mode.
- R12: At most one strobe is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write-cycle pulse |
| wr_addr | input | ADDR_W | Latched write address |
| wr_data | input | DATA_W | Latched write data |
| busy | input | 1 | Embedded algorithm running; writes ignored |
| pgm_stb | output | 1 | Program request |
| chip_erase_stb | output | 1 | Chip erase request |
| sec_erase_stb | output | 1 | Sector erase request |
| sec_lock_stb | output | 1 | Sector lock request |
| susp_stb | output | 1 | Erase suspend request |
| resume_stb | output | 1 | Erase resume request |
| id_enter_stb | output | 1 | Identification mode entered |
| id_exit_stb | output | 1 | Identification mode left |
| prot_pgm_stb | output | 1 | Protection-register program request |
| prot_lock_stb | output | 1 | Protection-register lock request |
| op_addr | output | ADDR_W | Address of the completing write |
| op_data | output | DATA_W | Data of the completing write |
| id_mode | output | 1 | Identification mode flag |
| sp_mode | output | 1 | Single-pulse program mode flag |

## Verification
The bench builds the decoder with its defaults: a 21-bit address and a 16-bit data bus. This width is what brings the plane bits 20:19 of a resume onto `op_addr`. It also lets the bench drive unlock writes with address bits above 10 and data bits above 7 set, to show that those bits are ignored. The 16-bit data field also lets program data with a non-zero upper byte travel through unchanged.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              pgm_stb,
  output logic              chip_erase_stb,
  output logic              sec_erase_stb,
  output logic              sec_lock_stb,
  output logic              susp_stb,
  output logic              resume_stb,
  output logic              id_enter_stb,
  output logic              id_exit_stb,
  output logic              prot_pgm_stb,
  output logic              prot_lock_stb,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode,
  output logic              sp_mode
);
  localparam logic [10:0] A_FIRST = 11'h555;
  localparam logic [10:0] A_SECOND = 11'h2AA;
  localparam logic [10:0] A_PLOCK = 11'h080;
  localparam int NSTB = 10;
  localparam int B_PGM = 0, B_CE = 1, B_SE = 2, B_LK = 3, B_SUS = 4;
  localparam int B_RES = 5, B_IDE = 6, B_IDX = 7, B_PPG = 8, B_PLK = 9;

  typedef enum logic [2:0] {
    S_IDLE, S_UL1, S_UL2, S_PGM, S_PROT, S_ER3, S_ER4, S_ER5
  } seq_t;

  seq_t            st, nst;
  logic [NSTB-1:0] stb, nstb;
  logic            sp_set;

  wire       take   = wr_en && !busy;
  wire [7:0] cbyte  = wr_data[7:0];
  wire       at_one = wr_addr[10:0] == A_FIRST;
  wire       at_two = wr_addr[10:0] == A_SECOND;

  always_comb begin
    nst    = st;
    nstb   = '0;
    sp_set = 1'b0;
    if (take) begin
      nst = S_IDLE;
      if (sp_mode) nstb[B_PGM] = 1'b1;
      else begin
        case (st)
          S_IDLE: begin
            if (cbyte == 8'hAA && at_one) nst = S_UL1;
            else if (cbyte == 8'hB0)      nstb[B_SUS] = 1'b1;
            else if (cbyte == 8'h30)      nstb[B_RES] = 1'b1;
            else if (cbyte == 8'hF0)      nstb[B_IDX] = 1'b1;
          end
          S_UL1: if (cbyte == 8'h55 && at_two) nst = S_UL2;
          S_UL2: if (at_one) begin
            case (cbyte)
              8'hA0:   nst = S_PGM;
              8'hC0:   nst = S_PROT;
              8'h80:   nst = S_ER3;
              8'h90:   nstb[B_IDE] = 1'b1;
              8'hF0:   nstb[B_IDX] = 1'b1;
              default: ;
            endcase
          end
          S_PGM: nstb[B_PGM] = 1'b1;
          S_PROT: begin
            if (wr_addr[10:0] == A_PLOCK) nstb[B_PLK] = !wr_data[1];
            else                          nstb[B_PPG] = 1'b1;
          end
          S_ER3: if (cbyte == 8'hAA && at_one) nst = S_ER4;
          S_ER4: if (cbyte == 8'h55 && at_two) nst = S_ER5;
          S_ER5: begin
            case (cbyte)
              8'h10:   nstb[B_CE] = at_one;
              8'h30:   nstb[B_SE] = 1'b1;
              8'h60:   nstb[B_LK] = 1'b1;
              8'hA0:   sp_set = at_one;
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      stb     <= '0;
      id_mode <= 1'b0;
      sp_mode <= 1'b0;
      op_addr <= '0;
      op_data <= '0;
    end else begin
      st  <= nst;
      stb <= nstb;
      if (take) begin
        op_addr <= wr_addr;
        op_data <= wr_data;
      end
      if (sp_set)          sp_mode <= 1'b1;
      if (nstb[B_IDE])      id_mode <= 1'b1;
      else if (nstb[B_IDX]) id_mode <= 1'b0;
    end
  end

  assign pgm_stb        = stb[B_PGM];
  assign chip_erase_stb = stb[B_CE];
  assign sec_erase_stb  = stb[B_SE];
  assign sec_lock_stb   = stb[B_LK];
  assign susp_stb       = stb[B_SUS];
  assign resume_stb     = stb[B_RES];
  assign id_enter_stb   = stb[B_IDE];
  assign id_exit_stb    = stb[B_IDX];
  assign prot_pgm_stb   = stb[B_PPG];
  assign prot_lock_stb  = stb[B_PLK];

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pgm_stb, chip_erase_stb, sec_erase_stb, sec_lock_stb, susp_stb,
              resume_stb, id_enter_stb, id_exit_stb, prot_pgm_stb, prot_lock_stb}));

  a_r10_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(pgm_stb || chip_erase_stb || sec_erase_stb || sec_lock_stb || susp_stb ||
               resume_stb || id_enter_stb || id_exit_stb || prot_pgm_stb || prot_lock_stb));

  a_r11_sp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sp_mode |=> sp_mode);

  a_r11_sp_only_pgm: assert property (@(posedge clk) disable iff (!rst_n)
    sp_mode |=> !(chip_erase_stb || sec_erase_stb || sec_lock_stb || susp_stb || resume_stb));

  a_r4_id_enter: assert property (@(posedge clk) disable iff (!rst_n)
    id_enter_stb |-> id_mode);

  a_r4_id_exit: assert property (@(posedge clk) disable iff (!rst_n)
    id_exit_stb |-> !id_mode);

  a_r3_pgm_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !busy && !sp_mode |=> !pgm_stb || st == S_IDLE);
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam logic [9:0] K_NONE = 10'd0;
  localparam logic [9:0] K_PGM  = 10'b0000000001;
  localparam logic [9:0] K_CE   = 10'b0000000010;
  localparam logic [9:0] K_SE   = 10'b0000000100;
  localparam logic [9:0] K_LK   = 10'b0000001000;
  localparam logic [9:0] K_SUS  = 10'b0000010000;
  localparam logic [9:0] K_RES  = 10'b0000100000;
  localparam logic [9:0] K_IDE  = 10'b0001000000;
  localparam logic [9:0] K_IDX  = 10'b0010000000;
  localparam logic [9:0] K_PPG  = 10'b0100000000;
  localparam logic [9:0] K_PLK  = 10'b1000000000;

  logic clk = 0, rst_n = 0, wr_en = 0, busy = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic pgm_stb, chip_erase_stb, sec_erase_stb, sec_lock_stb, susp_stb, resume_stb;
  logic id_enter_stb, id_exit_stb, prot_pgm_stb, prot_lock_stb, id_mode, sp_mode;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .pgm_stb(pgm_stb), .chip_erase_stb(chip_erase_stb),
    .sec_erase_stb(sec_erase_stb), .sec_lock_stb(sec_lock_stb), .susp_stb(susp_stb),
    .resume_stb(resume_stb), .id_enter_stb(id_enter_stb), .id_exit_stb(id_exit_stb),
    .prot_pgm_stb(prot_pgm_stb), .prot_lock_stb(prot_lock_stb), .op_addr(op_addr),
    .op_data(op_data), .id_mode(id_mode), .sp_mode(sp_mode));

  typedef struct {
    logic [9:0]    kind;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string         req;
  } exp_t;

  exp_t q[$];
  int tests = 0, fails = 0, stray = 0;
  bit done = 0;

  wire [9:0] obs = {prot_lock_stb, prot_pgm_stb, id_exit_stb, id_enter_stb, resume_stb,
                    susp_stb, sec_lock_stb, sec_erase_stb, chip_erase_stb, pgm_stb};

  always @(negedge clk) begin
    if (rst_n && !done && obs != 10'd0) begin
      tests++;
      if (q.size() == 0) begin
        stray++; fails++;
        $display("FAIL R9 unexpected strobe: actual %b expected %b", obs, K_NONE);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (obs !== e.kind || op_addr !== e.a || op_data !== e.d) begin
          fails++;
          $display("FAIL %s strobe/addr/data: actual %b %h %h expected %b %h %h",
                   e.req, obs, op_addr, op_data, e.kind, e.a, e.d);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [9:0] k, input string req);
    @(negedge clk);
    if (k != K_NONE) begin
      exp_t e;
      e.kind = k; e.a = a; e.d = d; e.req = req;
      q.push_back(e);
    end
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic unlock();
    wr(21'h000555, 16'h00AA, K_NONE, "");
    wr(21'h000AAA, 16'h0055, K_NONE, "");
  endtask

  task automatic erase_prefix();
    unlock();
    wr(21'h000555, 16'h0080, K_NONE, "");
    wr(21'h000555, 16'h00AA, K_NONE, "");
    wr(21'h0002AA, 16'h0055, K_NONE, "");
  endtask

  task automatic drain(input string req);
    repeat (3) @(negedge clk);
    tests++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL %s missing strobe: actual %0d pending expected 0", req, q.size());
      q.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(obs != 10'd0, 1'b0, "R1", "strobes in reset");
    chk(sp_mode, 1'b0, "R1", "sp_mode in reset");
    rst_n = 1;
    @(negedge clk);
    chk(id_mode, 1'b0, "R1", "id_mode after reset");

    unlock(); wr(21'h000555, 16'h00A0, K_NONE, "");
    wr(21'h012345, 16'h1234, K_PGM, "R3");
    drain("R3");

    wr(21'h1FF555, 16'hFFAA, K_NONE, "");
    wr(21'h0402AA, 16'h3C55, K_NONE, "");
    wr(21'h100555, 16'h77A0, K_NONE, "");
    wr(21'h0ABCDE, 16'hBEEF, K_PGM, "R2");
    drain("R2");

    unlock(); wr(21'h000555, 16'h0090, K_IDE, "R4");
    drain("R4");
    chk(id_mode, 1'b1, "R4", "id_mode after entry");
    wr(21'h1F0123, 16'h00F0, K_IDX, "R4");
    drain("R4");
    chk(id_mode, 1'b0, "R4", "id_mode after lone exit");
    unlock(); wr(21'h000555, 16'h0090, K_IDE, "R4");
    unlock(); wr(21'h000555, 16'h00F0, K_IDX, "R4");
    drain("R4");
    chk(id_mode, 1'b0, "R4", "id_mode after long exit");

    erase_prefix(); wr(21'h000555, 16'h0010, K_CE, "R5");
    erase_prefix(); wr(21'h0ABCDE, 16'h0030, K_SE, "R5");
    drain("R5");
    erase_prefix(); wr(21'h1F8000, 16'h0060, K_LK, "R6");
    drain("R6");

    wr(21'h000123, 16'h00B0, K_SUS, "R7");
    wr(21'h180000, 16'h0030, K_RES, "R7");
    drain("R7");
    tests++;
    if (op_addr[20:19] !== 2'b11) begin
      fails++;
      $display("FAIL R7 plane: actual %b expected %b", op_addr[20:19], 2'b11);
    end

    unlock(); wr(21'h000555, 16'h00C0, K_NONE, "");
    wr(21'h000085, 16'h5A5A, K_PPG, "R8");
    unlock(); wr(21'h000555, 16'h00C0, K_NONE, "");
    wr(21'h000080, 16'h00FD, K_PLK, "R8");
    begin
      int s0 = stray;
      unlock(); wr(21'h000555, 16'h00C0, K_NONE, "");
      wr(21'h000080, 16'h0002, K_NONE, "");
      drain("R8");
      chk(stray != s0, 1'b0, "R8", "strobe for lock with bit1 set");
    end

    begin
      int s0 = stray;
      wr(21'h000555, 16'h00AA, K_NONE, "");
      wr(21'h000AAA, 16'h0056, K_NONE, "");
      wr(21'h000555, 16'h00A0, K_NONE, "");
      wr(21'h000100, 16'h1111, K_NONE, "");
      erase_prefix(); wr(21'h000556, 16'h0010, K_NONE, "");
      drain("R9");
      chk(stray != s0, 1'b0, "R9", "strobe after mismatch");
    end

    begin
      int s0 = stray;
      busy = 1;
      wr(21'h000000, 16'h00B0, K_NONE, "");
      unlock();
      busy = 0;
      drain("R10");
      chk(stray != s0, 1'b0, "R10", "strobe while busy");
      wr(21'h000000, 16'h00B0, K_SUS, "R10");
      drain("R10");
    end

    erase_prefix(); wr(21'h000555, 16'h00A0, K_NONE, "");
    drain("R11");
    chk(sp_mode, 1'b1, "R11", "sp_mode set");
    wr(21'h000010, 16'h00B0, K_PGM, "R11");
    wr(21'h000020, 16'h0030, K_PGM, "R11");
    wr(21'h000555, 16'h00AA, K_PGM, "R11");
    drain("R11");
    chk(sp_mode, 1'b1, "R11", "sp_mode sticky");

    @(negedge clk); rst_n = 0;
    @(negedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(sp_mode, 1'b0, "R1", "sp_mode after reset");
    chk(id_mode, 1'b0, "R1", "id_mode after reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule